// File: doc/BRIEF.md
# Broadcast DAC Ramp Stimulus Generator

This block is a transmit-only host controller for a four-channel serial DAC on a three-wire link (active-low select, serial clock, serial data) plus an active-low clear line. It needs no inputs beyond clock and reset. After reset it pulses the DAC clear. It then sends 16-bit frames back to back. Every frame carries the command that loads and updates all four channels together, followed by a 12-bit code that rises by one per frame. The result is a continuous sawtooth on every DAC output.

A trigger output gives an oscilloscope a fixed time reference on the ramp. It pulses once per sawtooth period, in the idle gap right after the frame whose code was zero. The parameter `HALF_CYCLES` sets the serial clock half-period in system clocks. Every phase of the link lasts one such half-period, so a frame slot is always 34 half-periods long, whether or not the trigger fires.

Top module: `dac_ramp_gen`

## Requirements
- R1: While reset is held and for the first half-period after reset is released, `dacClearN` is 0, `dacSelN` is 1, and `dacSclk` and `dacSdata` are 0. From then on, `dacClearN` is 1 and stays 1 until the next reset.
- R2: Each frame shifts 16 bits out most-significant bit first. Bits 15:12 are always 1110, the broadcast load-and-update command. Bits 11:0 carry the ramp code.
- R3: The first frame after reset carries code 0. Each later frame carries the previous code plus one, modulo 4096, so code 4095 is followed by code 0.
- R4: For each bit, `dacSclk` is 0 for one half-period and then 1 for one half-period. The bit is present on `dacSdata` for both halves. `dacSclk` is only ever 1 while `dacSelN` is 0.
- R5: `dacSelN` falls at the start of the low half of the first bit. After the high half of the 16th bit, `dacSclk` stays 0 for one more half-period with `dacSelN` still 0, and then `dacSelN` rises.
- R6: Between frames, `dacSelN` is 1 for exactly one half-period. The first frame starts one half-period after `dacClearN` rises, and frames repeat every 34 half-periods.
- R7: `scopeTrig` is 1 for exactly the one-half-period gap that follows a frame carrying code 0. It is 0 at all other times, including the gap before the first frame.
- R8: One half-period equals `HALF_CYCLES` system clock cycles, and the value 1 is allowed.
- R9: `dacSdata` is 0 whenever `dacSelN` is 1.
- R10: Asserting `rstN` at any point, including in the middle of a frame, forces the R1 reset values at once. After release, the sequence restarts from the clear phase with code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dacSelN | output | 1 | Active-low DAC chip select |
| dacSclk | output | 1 | Serial clock; the DAC samples data on its rising edge |
| dacSdata | output | 1 | Serial data, most-significant bit first |
| dacClearN | output | 1 | Active-low DAC clear, pulsed once after reset |
| scopeTrig | output | 1 | One-half-period trigger after each code-0 frame |

## Verification
The bench runs one instance for more than 4096 frames. This reaches the code wrap from 4095 back to 0: a counter that saturates would never trigger again, and one that skips the wrap would trigger at the wrong frame. A second instance with a half-period of three clocks exposes divider faults, where phases would last the wrong number of cycles. Resets at random points in the middle of a frame check that no stale shift data, bit count or code survives: a leftover would show up as a wrong first bit or a first frame that does not start at code 0. The bench compares every output in every cycle against a model built from the requirements. That comparison catches a missing tail phase, a gap that is too long, and data left on the line while select is high.

// File: rtl/dac_ramp_pkg.sv
package dac_ramp_pkg;

  // Width of the command nibble at the head of every frame.
  localparam int CMD_W = 4;

  // Broadcast load-and-update command.
  localparam logic [CMD_W-1:0] BCAST_LOAD_UPDATE = 4'b1110;

  // Strobes that the control sends to the datapath.
  typedef struct packed {
    logic loadFrame;  // copy command and code into the shifter
    logic shiftBit;   // advance the shifter by one bit
    logic bumpCode;   // step the ramp code
  } rampStrobes_t;

  // Link phases; each one lasts one serial half-period.
  typedef enum logic [2:0] {
    PH_CLEAR,
    PH_GAP,
    PH_LOW,
    PH_HIGH,
    PH_TAIL
  } rampPhase_t;

endpackage

// File: rtl/ramp_datapath.sv
module ramp_datapath
  import dac_ramp_pkg::*;
#(
  parameter int CODE_W  = 12,
  parameter int FRAME_W = CMD_W + CODE_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  rampStrobes_t stb,
  output logic         serData,
  output logic         frameWasZero
);

  logic [FRAME_W-1:0] shiftReg;
  logic [CODE_W-1:0]  code;
  logic               sentZero;

  // The frame shifter fills with zeros from the bottom. One shift after the
  // last bit therefore leaves the register clear, so the data line rests low.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sentZero <= 1'b0;
    end else if (stb.loadFrame) begin
      shiftReg <= {BCAST_LOAD_UPDATE, code};
      sentZero <= (code == '0);
    end else if (stb.shiftBit) begin
      shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
    end
  end

  // The ramp code wraps naturally at its width.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      code <= '0;
    end else if (stb.bumpCode) begin
      code <= code + 1'b1;
    end
  end

  assign serData      = shiftReg[FRAME_W-1];
  assign frameWasZero = sentZero;

  // R2: a freshly loaded frame carries the broadcast command on top
  assert_cmd_nibble_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadFrame |=> shiftReg[FRAME_W-1 -: CMD_W] == BCAST_LOAD_UPDATE);

  // R3: the code steps by exactly one, modulo its width
  assert_code_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.bumpCode |=> code == CODE_W'($past(code) + 1'b1));

endmodule

// File: rtl/ramp_ctrl.sv
module ramp_ctrl
  import dac_ramp_pkg::*;
#(
  parameter int HALF_CYCLES = 4,
  parameter int FRAME_W     = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameWasZero,
  output rampStrobes_t stb,
  output logic         selN,
  output logic         serClk,
  output logic         clearN,
  output logic         trigger
);

  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  logic tick;

  // Half-period timebase; a divide-by-one needs no counter.
  generate
    if (HALF_CYCLES <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DIV_W = $clog2(HALF_CYCLES);
      localparam logic [DIV_W-1:0] DIV_END = DIV_W'(HALF_CYCLES - 1);
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              divCnt <= '0;
        else if (divCnt == DIV_END) divCnt <= '0;
        else                    divCnt <= divCnt + 1'b1;
      end
      assign tick = (divCnt == DIV_END);
    end
  endgenerate

  rampPhase_t phase, phaseNext;
  logic [BIT_W-1:0] bitIdx;
  logic lastBit;

  assign lastBit = (bitIdx == LAST_BIT);

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_CLEAR: phaseNext = PH_GAP;
      PH_GAP:   phaseNext = PH_LOW;
      PH_LOW:   phaseNext = PH_HIGH;
      PH_HIGH:  phaseNext = lastBit ? PH_TAIL : PH_LOW;
      PH_TAIL:  phaseNext = PH_GAP;
      default:  phaseNext = PH_CLEAR;
    endcase
  end

  always_comb begin
    stb.loadFrame = tick && (phase == PH_GAP);
    stb.shiftBit  = tick && (phase == PH_HIGH);
    stb.bumpCode  = tick && (phase == PH_TAIL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_CLEAR;
      bitIdx <= '0;
    end else if (tick) begin
      phase <= phaseNext;
      if (phase == PH_GAP)                 bitIdx <= '0;
      else if (phase == PH_HIGH && !lastBit) bitIdx <= bitIdx + 1'b1;
    end
  end

  assign clearN  = (phase != PH_CLEAR);
  assign selN    = (phase == PH_CLEAR) || (phase == PH_GAP);
  assign serClk  = (phase == PH_HIGH);
  assign trigger = (phase == PH_GAP) && frameWasZero;

  // R4: the serial clock never rises outside a frame
  assert_sclk_in_frame_R4: assert property (@(posedge clk) disable iff (!rstN)
    serClk |-> !selN);

  // R1: once released, clear stays high until the next reset
  assert_clear_holds_R1: assert property (@(posedge clk) disable iff (!rstN)
    clearN |=> clearN);

  // R7: the trigger only ever appears in the gap between frames
  assert_trig_in_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
    trigger |-> (selN && clearN));

endmodule

// File: rtl/dac_ramp_gen.sv
module dac_ramp_gen
  import dac_ramp_pkg::*;
#(
  parameter int HALF_CYCLES = 4,
  parameter int CODE_W      = 12
) (
  input  logic clk,
  input  logic rstN,
  output logic dacSelN,
  output logic dacSclk,
  output logic dacSdata,
  output logic dacClearN,
  output logic scopeTrig
);

  localparam int FRAME_W = CMD_W + CODE_W;

  rampStrobes_t stb;
  logic frameWasZero;

  ramp_ctrl #(
    .HALF_CYCLES(HALF_CYCLES),
    .FRAME_W    (FRAME_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .frameWasZero(frameWasZero),
    .stb         (stb),
    .selN        (dacSelN),
    .serClk      (dacSclk),
    .clearN      (dacClearN),
    .trigger     (scopeTrig)
  );

  ramp_datapath #(
    .CODE_W (CODE_W),
    .FRAME_W(FRAME_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .serData     (dacSdata),
    .frameWasZero(frameWasZero)
  );

  // R9: the data line rests low whenever select is inactive
  assert_data_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    dacSelN |-> !dacSdata);

endmodule

// File: tb/sim_dac_ramp_gen.sv
module sim_dac_ramp_gen;

  typedef struct packed {
    logic clr;
    logic sel;
    logic sck;
    logic sdi;
    logic trig;
  } pins_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;  // 200 MHz

  logic sel0, sck0, sdi0, clr0, trg0;
  logic sel1, sck1, sdi1, clr1, trg1;

  dac_ramp_gen #(.HALF_CYCLES(1)) u0 (
    .clk(clk), .rstN(rstN), .dacSelN(sel0), .dacSclk(sck0),
    .dacSdata(sdi0), .dacClearN(clr0), .scopeTrig(trg0)
  );

  dac_ramp_gen #(.HALF_CYCLES(3)) u1 (
    .clk(clk), .rstN(rstN), .dacSelN(sel1), .dacSclk(sck1),
    .dacSdata(sdi1), .dacClearN(clr1), .scopeTrig(trg1)
  );

  int checks = 0;
  int errors = 0;
  int n = 0;          // posedges since reset release
  bit done = 1'b0;
  int trigRise0 = 0;
  int trigRise1 = 0;
  logic trgPrev0 = 1'b0;
  logic trgPrev1 = 1'b0;

  // Expected pins after cnt clocks since release, for a given half-period.
  function automatic pins_t expectPins(int cnt, int h);
    pins_t e;
    int p, q, k, i;
    logic [15:0] frame;
    e = '{clr: 1'b0, sel: 1'b1, sck: 1'b0, sdi: 1'b0, trig: 1'b0};
    p = cnt / h;
    if (p == 0) return e;   // R1 clear phase
    e.clr = 1'b1;
    if (p == 1) return e;   // R6 first gap, R7 no trigger yet
    q = (p - 2) % 34;
    k = (p - 2) / 34;
    if (q < 32) begin
      i = q / 2;
      frame = {4'b1110, 12'(k % 4096)};
      e.sel = 1'b0;
      e.sck = q[0];
      e.sdi = frame[15 - i];
    end else if (q == 32) begin
      e.sel = 1'b0;          // R5 tail half-period
    end else begin
      e.trig = ((k % 4096) == 0);
    end
    return e;
  endfunction

  // Requirement that owns a data-bit mismatch.
  function automatic string sdiTag(int cnt, int h);
    int p, q;
    p = cnt / h;
    if (p < 2) return "R9";
    q = (p - 2) % 34;
    if (q >= 32) return "R9";
    if (q / 2 < 4) return "R2";
    return "R3";
  endfunction

  task automatic checkBit(string who, string sig, string req,
                          logic act, logic exp, int cnt);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s %s at cycle %0d: actual %b expected %b",
               req, who, sig, cnt, act, exp);
    end
  endtask

  task automatic checkPins(string who, int h, int cnt, pins_t act);
    pins_t e;
    string tagClk;
    e = expectPins(cnt, h);
    tagClk = (h > 1) ? "R4/R8" : "R4";
    checkBit(who, "dacClearN", "R1", act.clr, e.clr, cnt);
    checkBit(who, "dacSelN", (e.sel ? "R6" : "R5"), act.sel, e.sel, cnt);
    checkBit(who, "dacSclk", tagClk, act.sck, e.sck, cnt);
    checkBit(who, "dacSdata", sdiTag(cnt, h), act.sdi, e.sdi, cnt);
    checkBit(who, "scopeTrig", "R7", act.trig, e.trig, cnt);
  endtask

  always @(posedge clk) begin
    if (!rstN) n <= 0;
    else       n <= n + 1;
  end

  // Every-cycle comparison, away from the active edge. R10: under reset the
  // model position is zero, which is the R1 reset state.
  always @(negedge clk) begin
    int eff;
    if (!done) begin
      eff = rstN ? n : 0;
      checkPins("u0", 1, eff, '{clr: clr0, sel: sel0, sck: sck0, sdi: sdi0, trig: trg0});
      checkPins("u1", 3, eff, '{clr: clr1, sel: sel1, sck: sck1, sdi: sdi1, trig: trg1});
      if (trg0 && !trgPrev0) trigRise0++;
      if (trg1 && !trgPrev1) trigRise1++;
      trgPrev0 = trg0;
      trgPrev1 = trg1;
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R10: random mid-frame resets of random length
    for (int r = 0; r < 6; r++) begin
      repeat (50 + ($urandom % 1950)) @(posedge clk);
      #1 rstN = 1'b0;
      repeat (1 + ($urandom % 5)) @(posedge clk);
      #1 rstN = 1'b1;
    end
    trigRise0 = 0;
    trigRise1 = 0;
    // Long run past the 4095 -> 0 wrap of u0 (frame 4096 gap at cycle 139299)
    repeat (139400) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    // R3/R7: u0 sees code 0 at frame 0 and again after the wrap
    checks++;
    if (trigRise0 != 2) begin
      errors++;
      $display("FAIL R3 u0 trigger count after wrap: actual %0d expected 2", trigRise0);
    end
    // R7/R8: the slower instance has not wrapped yet
    checks++;
    if (trigRise1 != 1) begin
      errors++;
      $display("FAIL R7 u1 trigger count: actual %0d expected 1", trigRise1);
    end
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      summary();
    end
  end

endmodule